// File: doc/BRIEF.md
# Posted Write Abort Status Logic

This block sits in a bridge that forwards posted writes from a primary side onto a secondary PCI/PCI-X bus. When such a write ends at once on the secondary bus, the bus engine presents a one-cycle termination event with a code. The block turns that event into sticky error status and, when needed, a request to send a system-error message upstream.

A master abort is only escalated to a system-error message when the master-abort escalation bit is set. A target abort is always escalated. Every escalation is further gated by the primary SERR enable bit. The two secondary received-abort bits are set whenever their abort occurs, whether or not SERR is enabled. Software clears the status bits by writing ones. The system-error request stays high until the upstream message path acknowledges it.

Top module: `pw_abort_status`

## Requirements
- R1: After reset, `status` is 3'b000 and `err_req` is 0.
- R2: A successful termination (code 2'b00) leaves `status` and `err_req` unchanged.
- R3: A master abort (code 2'b01) with `ma_escalate`=1 and `serr_en`=1 sets status bit 0 (secondary received master abort) and bit 2 (primary signaled system error), and raises `err_req` on the next cycle.
- R4: A master abort with `ma_escalate`=0 sets only status bit 0 and does not raise `err_req`.
- R5: A target abort (code 2'b10) sets status bit 1 (secondary received target abort). With `serr_en`=1 it also sets bit 2 and raises `err_req`, whatever the value of `ma_escalate`.
- R6: With `serr_en`=0, no termination sets status bit 2 or raises `err_req`, but bits 0 and 1 are still set by their aborts.
- R7: Status bits are sticky. A cycle with `clr_we`=1 clears exactly the bits that are 1 in `clr_data`; zero bits in `clr_data`, or `clr_we`=0, leave bits unchanged.
- R8: When a bit is set by an event and cleared by a write in the same cycle, it ends up set.
- R9: `err_req` stays high until a cycle with `err_ack`=1, then falls on the next cycle, unless a new escalating event arrives in that same cycle, in which case it stays high.
- R10: A termination with `term_valid`=0, or with the unused code 2'b11, has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| term_valid | input | 1 | One-cycle termination event strobe |
| term_code | input | 2 | 00 success, 01 master abort, 10 target abort, 11 unused |
| ma_escalate | input | 1 | Escalate master aborts to a system-error message |
| serr_en | input | 1 | Primary SERR enable |
| clr_we | input | 1 | Write strobe for the write-1-to-clear status port |
| clr_data | input | 3 | Bits to clear: 0 master abort, 1 target abort, 2 system error |
| err_ack | input | 1 | Upstream acknowledge of the system-error request |
| err_req | output | 1 | System-error message request, held until acknowledged |
| status | output | 3 | Sticky status: 0 received master abort, 1 received target abort, 2 signaled system error |

## Verification
Two functions can coincide in one cycle: an abort event that sets a status bit while software writes a one to clear the same bit, and an escalating event while the pending request is being acknowledged. The bench provokes both by driving the event, the clear strobe and the acknowledge in the same cycle. It judges the first by reading the status bit afterwards (it must be set) and the second by checking that `err_req` stays high and then drops after a later acknowledge.

// File: rtl/pw_abort_pkg.sv
package pw_abort_pkg;

  localparam int STAT_W  = 3;
  localparam int RMA_BIT = 0;
  localparam int RTA_BIT = 1;
  localparam int SSE_BIT = 2;

  typedef enum logic [1:0] {
    TERM_OK     = 2'b00,
    TERM_MABORT = 2'b01,
    TERM_TABORT = 2'b10,
    TERM_UNUSED = 2'b11
  } term_code_e;

  // Whether a termination asks for escalation upstream
  function automatic logic wants_escalation(input logic [1:0] code,
                                            input logic       ma_esc);
    logic r;
    r = 1'b0;
    if (code == TERM_TABORT) r = 1'b1;
    else if (code == TERM_MABORT) r = ma_esc;
    return r;
  endfunction

  // Status bits a single termination sets
  function automatic logic [STAT_W-1:0] term_set_vec(input logic       valid,
                                                     input logic [1:0] code,
                                                     input logic       ma_esc,
                                                     input logic       serr);
    logic [STAT_W-1:0] v;
    v = '0;
    if (valid) begin
      v[RMA_BIT] = (code == TERM_MABORT);
      v[RTA_BIT] = (code == TERM_TABORT);
      v[SSE_BIT] = serr & wants_escalation(code, ma_esc);
    end
    return v;
  endfunction

endpackage

// File: rtl/pw_term_decode.sv
module pw_term_decode
  import pw_abort_pkg::*;
(
  input  logic              term_valid,
  input  logic [1:0]        term_code,
  input  logic              ma_escalate,
  input  logic              serr_en,
  output logic [STAT_W-1:0] set_vec,
  output logic              fire
);

  always_comb begin
    set_vec = term_set_vec(term_valid, term_code, ma_escalate, serr_en);
    fire    = set_vec[SSE_BIT];
  end

endmodule

// File: rtl/pw_status_w1c.sv
module pw_status_w1c #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_vec,
  input  logic         clr_we,
  input  logic [W-1:0] clr_data,
  output logic [W-1:0] q
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic clr_hit;
    assign clr_hit = clr_we & clr_data[i];
    always_ff @(posedge clk) begin
      if (!rst_n)          q[i] <= 1'b0;
      else if (set_vec[i]) q[i] <= 1'b1;   // set has priority
      else if (clr_hit)    q[i] <= 1'b0;
    end
  end

endmodule

// File: rtl/pw_err_req.sv
module pw_err_req (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  logic ack,
  output logic req
);

  logic req_nxt;

  always_comb begin
    req_nxt = fire | (req & ~ack);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) req <= 1'b0;
    else        req <= req_nxt;
  end

endmodule

// File: rtl/pw_abort_status.sv
module pw_abort_status
  import pw_abort_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              term_valid,
  input  logic [1:0]        term_code,
  input  logic              ma_escalate,
  input  logic              serr_en,
  input  logic              clr_we,
  input  logic [STAT_W-1:0] clr_data,
  input  logic              err_ack,
  output logic              err_req,
  output logic [STAT_W-1:0] status
);

  // Internal events, named for the checker
  logic [STAT_W-1:0] evt_set;
  logic              evt_fire;

  pw_term_decode u_dec (
    .term_valid  (term_valid),
    .term_code   (term_code),
    .ma_escalate (ma_escalate),
    .serr_en     (serr_en),
    .set_vec     (evt_set),
    .fire        (evt_fire)
  );

  pw_status_w1c #(.W(STAT_W)) u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_vec  (evt_set),
    .clr_we   (clr_we),
    .clr_data (clr_data),
    .q        (status)
  );

  pw_err_req u_req (
    .clk   (clk),
    .rst_n (rst_n),
    .fire  (evt_fire),
    .ack   (err_ack),
    .req   (err_req)
  );

endmodule

// File: rtl/pw_abort_status_chk.sv
module pw_abort_status_chk
  import pw_abort_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              term_valid,
  input logic [1:0]        term_code,
  input logic              ma_escalate,
  input logic              serr_en,
  input logic              clr_we,
  input logic [STAT_W-1:0] clr_data,
  input logic              err_ack,
  input logic              err_req,
  input logic [STAT_W-1:0] status,
  input logic [STAT_W-1:0] evt_set,
  input logic              evt_fire
);

  logic [STAT_W-1:0] clr_mask;
  assign clr_mask = clr_we ? clr_data : '0;

  p_req_needs_serr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_req) |-> $past(term_valid && serr_en));

  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (err_req && !err_ack) |=> err_req);

  p_fire_raises_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    evt_fire |=> (err_req && status[SSE_BIT]));

  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(status) & ~$past(clr_mask) & ~status) == '0));

  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_set[RMA_BIT] && clr_mask[RMA_BIT]) |=> status[RMA_BIT]);

  p_ma_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (term_valid && term_code == TERM_MABORT && !ma_escalate && !err_req) |=> !err_req);

  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!term_valid || term_code == TERM_UNUSED) |-> (evt_set == '0));

endmodule

bind pw_abort_status pw_abort_status_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .term_valid  (term_valid),
  .term_code   (term_code),
  .ma_escalate (ma_escalate),
  .serr_en     (serr_en),
  .clr_we      (clr_we),
  .clr_data    (clr_data),
  .err_ack     (err_ack),
  .err_req     (err_req),
  .status      (status),
  .evt_set     (evt_set),
  .evt_fire    (evt_fire)
);

// File: tb/pw_abort_status_tb.sv
`timescale 1ns/1ps
module pw_abort_status_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       term_valid;
  logic [1:0] term_code;
  logic       ma_escalate;
  logic       serr_en;
  logic       clr_we;
  logic [2:0] clr_data;
  logic       err_ack;
  logic       err_req;
  logic [2:0] status;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  pw_abort_status u_dut (
    .clk(clk), .rst_n(rst_n), .term_valid(term_valid), .term_code(term_code),
    .ma_escalate(ma_escalate), .serr_en(serr_en), .clr_we(clr_we),
    .clr_data(clr_data), .err_ack(err_ack), .err_req(err_req), .status(status)
  );

  // {code[1:0], ma_escalate, serr_en, exp_status[2:0], exp_req}
  localparam int NVEC = 9;
  localparam logic [7:0] VEC [NVEC] = '{
    {2'b00, 1'b1, 1'b1, 3'b000, 1'b0},  // R2
    {2'b01, 1'b1, 1'b1, 3'b101, 1'b1},  // R3
    {2'b01, 1'b0, 1'b1, 3'b001, 1'b0},  // R4
    {2'b01, 1'b1, 1'b0, 3'b001, 1'b0},  // R6
    {2'b01, 1'b0, 1'b0, 3'b001, 1'b0},  // R4 R6
    {2'b10, 1'b0, 1'b1, 3'b110, 1'b1},  // R5
    {2'b10, 1'b1, 1'b1, 3'b110, 1'b1},  // R5
    {2'b10, 1'b0, 1'b0, 3'b010, 1'b0},  // R6
    {2'b11, 1'b1, 1'b1, 3'b000, 1'b0}   // R10
  };

  task automatic check(input string req, input logic [2:0] st_exp, input logic rq_exp);
    checks++;
    if (status !== st_exp || err_req !== rq_exp) begin
      errors++;
      $display("FAIL %s: status=%b err_req=%b expected status=%b err_req=%b",
               req, status, err_req, st_exp, rq_exp);
    end
  endtask

  // Drive one cycle of inputs, then sample after the edge
  task automatic step(input logic v, input logic [1:0] c, input logic m, input logic s,
                      input logic cw, input logic [2:0] cd, input logic a);
    @(negedge clk);
    term_valid = v; term_code = c; ma_escalate = m; serr_en = s;
    clr_we = cw; clr_data = cd; err_ack = a;
    @(posedge clk);
    #1;
    term_valid = 1'b0; clr_we = 1'b0; clr_data = 3'b000; err_ack = 1'b0;
  endtask

  task automatic cleanup();
    step(1'b0, 2'b00, 1'b0, 1'b1, 1'b1, 3'b111, 1'b1);
  endtask

  initial begin
    rst_n = 1'b0; term_valid = 1'b0; term_code = 2'b00; ma_escalate = 1'b0;
    serr_en = 1'b0; clr_we = 1'b0; clr_data = 3'b000; err_ack = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R1", 3'b000, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1", 3'b000, 1'b0);

    // Table walk
    for (int i = 0; i < NVEC; i++) begin
      step(1'b1, VEC[i][7:6], VEC[i][5], VEC[i][4], 1'b0, 3'b000, 1'b0);
      check("R2-table entry (R2/R3/R4/R5/R6/R10)", VEC[i][3:1], VEC[i][0]);
      cleanup();
      check("R7 cleanup", 3'b000, 1'b0);
    end

    // R10: strobe low with target abort code
    step(1'b0, 2'b10, 1'b1, 1'b1, 1'b0, 3'b000, 1'b0);
    check("R10", 3'b000, 1'b0);

    // R9: request held without ack
    step(1'b1, 2'b10, 1'b0, 1'b1, 1'b0, 3'b000, 1'b0);
    check("R9", 3'b110, 1'b1);
    for (int k = 0; k < 3; k++) begin
      step(1'b0, 2'b00, 1'b0, 1'b1, 1'b0, 3'b000, 1'b0);
      check("R9 hold", 3'b110, 1'b1);
    end
    // R9: new escalation in the ack cycle keeps request high
    step(1'b1, 2'b01, 1'b1, 1'b1, 1'b0, 3'b000, 1'b1);
    check("R9 merge", 3'b111, 1'b1);
    step(1'b0, 2'b00, 1'b0, 1'b1, 1'b0, 3'b000, 1'b1);
    check("R9 ack", 3'b111, 1'b0);

    // R7: write with clr_we low, and write of zeros, change nothing
    step(1'b0, 2'b00, 1'b0, 1'b1, 1'b0, 3'b111, 1'b0);
    check("R7 no strobe", 3'b111, 1'b0);
    step(1'b0, 2'b00, 1'b0, 1'b1, 1'b1, 3'b000, 1'b0);
    check("R7 zero write", 3'b111, 1'b0);
    // R7: partial clear
    step(1'b0, 2'b00, 1'b0, 1'b1, 1'b1, 3'b010, 1'b0);
    check("R7 partial", 3'b101, 1'b0);

    // R8: master abort sets bit 0 while it is cleared
    step(1'b1, 2'b01, 1'b0, 1'b1, 1'b1, 3'b001, 1'b0);
    check("R8", 3'b101, 1'b0);
    // R8: target abort sets bits 1,2 while all cleared
    step(1'b1, 2'b10, 1'b0, 1'b1, 1'b1, 3'b111, 1'b0);
    check("R8 all", 3'b110, 1'b1);
    cleanup();
    check("R7 final", 3'b000, 1'b0);

    // R1: reset mid-run
    step(1'b1, 2'b10, 1'b0, 1'b1, 1'b0, 3'b000, 1'b0);
    @(negedge clk); rst_n = 1'b0;
    @(posedge clk); #1;
    check("R1 reset", 3'b000, 1'b0);
    @(negedge clk); rst_n = 1'b1;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule